// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block supervises the supply from the digital side. A single input from an external comparator reports that the supply sits below the brown-out threshold. While detection is live, a dip that lasts long enough trips the block. The block then holds the device reset output for as long as the supply stays low. When the power-up hold is enabled, it keeps reset asserted for a further fixed number of clock cycles after the supply recovers. A dip that arrives during that hold sends the block back into the brown-out state and restarts the hold count from zero.

A two-bit arming code chooses how detection is gated. Detection can be always off or always on. It can follow a stored software arm bit. It can also run in every mode except sleep. Two status flags let software tell a brown-out apart from a power-on. Software sets both flags. A brown-out trip clears the brown-out flag, and a power-on reset clears both flags. The filter length and the hold length are parameters counted in clock cycles.

Top module: `supply_dip_guard`

## Requirements
- R1: With `arm_cfg` = 2'b00, detection is off, and `dev_reset` never rises, however long `low_supply` stays high.
- R2: With `arm_cfg` = 2'b01, detection follows the stored arm bit: 1 enables it and 0 disables it completely. The arm bit is written from `ctl_arm` when `ctl_we` is high, and it resets to 1 on power-on.
- R3: With `arm_cfg` = 2'b10, detection is live while `sleep_mode` = 0 and off while `sleep_mode` = 1.
- R4: With `arm_cfg` = 2'b11, detection is always live, and the stored arm bit has no effect.
- R5: `arm_rd` shows the stored arm bit when `arm_cfg` = 2'b01 and reads 0 under every other code.
- R6: While detection is live and `dev_reset` is low, `low_supply` sampled high on FILT_CYC consecutive clock edges raises `dev_reset` right after the last of those edges. A run of FILT_CYC-1 edges leaves it low.
- R7: Once raised, `dev_reset` stays high on every edge that samples `low_supply` high.
- R8: The first edge that samples `low_supply` low ends the brown-out state. With `hold_en` = 0, `dev_reset` falls on that edge. With `hold_en` = 1, it stays high for HOLD_CYC further edges and falls on the next one.
- R9: `low_supply` sampled high during the power-up hold returns the block to the brown-out state at once. After recovery, the full HOLD_CYC hold is served again.
- R10: `brn_flag` is set to 1 by `ctl_we` with `ctl_set_brn`. A brown-out trip clears it to 0, and a power-on reset clears it as well. When a trip and a set land on the same edge, the trip wins.
- R11: `pwr_flag` is set to 1 by `ctl_we` with `ctl_set_pwr`. Only a power-on reset clears it; brown-out events leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the filter and hold counters |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| low_supply | input | 1 | Comparator result, 1 when the supply is below threshold |
| arm_cfg | input | 2 | Detection arming code (see R1 to R4) |
| sleep_mode | input | 1 | 1 while the device is asleep |
| hold_en | input | 1 | Enables the power-up hold after recovery |
| ctl_we | input | 1 | Software write strobe |
| ctl_arm | input | 1 | Arm bit value stored on a write |
| ctl_set_brn | input | 1 | Sets the brown-out flag on a write |
| ctl_set_pwr | input | 1 | Sets the power-on flag on a write |
| dev_reset | output | 1 | Device reset request, active high |
| arm_rd | output | 1 | Arm bit as software reads it |
| brn_flag | output | 1 | Brown-out status flag |
| pwr_flag | output | 1 | Power-on status flag |

## Verification
Two events can hit the brown-out flag on the same edge: the trip that clears it and a software write that sets it. The bench runs a dip of exactly FILT_CYC edges and raises the set strobe on the final edge. It expects the flag at 0 and the reset at 1. A second overlap is a new dip during the power-up hold. The bench judges it by counting edges until reset falls again. The random phase mixes dips, write strobes, code changes and sleep toggles, and it compares every output on every edge against a bench model.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BROWN = 2'd1,
    ST_HOLD  = 2'd2
  } sdg_state_e;

  localparam logic [1:0] ARM_OFF  = 2'b00;
  localparam logic [1:0] ARM_SW   = 2'b01;
  localparam logic [1:0] ARM_WAKE = 2'b10;
  localparam logic [1:0] ARM_ON   = 2'b11;

  // Counter width for a count from 0 to n-1, never below 1 bit.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Detection gate for an arming code, a stored arm bit and the sleep state.
  function automatic logic arm_live(input logic [1:0] cfg, input logic sw_bit,
                                    input logic asleep);
    logic res;
    unique case (cfg)
      ARM_OFF:  res = 1'b0;
      ARM_SW:   res = sw_bit;
      ARM_WAKE: res = !asleep;
      default:  res = 1'b1;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/sdg_arm_decode.sv
module sdg_arm_decode
  import sdg_pkg::*;
(
  input  logic [1:0] arm_cfg,
  input  logic       sw_arm,
  input  logic       sleep_mode,
  output logic       live,
  output logic       arm_rd
);

  always_comb begin
    live   = arm_live(arm_cfg, sw_arm, sleep_mode);
    arm_rd = (arm_cfg == ARM_SW) && sw_arm;
  end

endmodule

// File: rtl/sdg_dip_filter.sv
module sdg_dip_filter
  import sdg_pkg::*;
#(
  parameter int FILT_CYC = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic count_en,
  output logic trip
);

  localparam int CW = cnt_width(FILT_CYC);
  localparam logic [CW-1:0] F_LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] dip_cnt;

  assign trip = count_en && (dip_cnt == F_LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 dip_cnt <= '0;
    else if (!count_en || trip) dip_cnt <= '0;
    else                        dip_cnt <= dip_cnt + 1'b1;
  end

endmodule

// File: rtl/sdg_seq.sv
module sdg_seq
  import sdg_pkg::*;
#(
  parameter int HOLD_CYC = 32
) (
  input  logic clk,
  input  logic por_n,
  input  logic trip,
  input  logic low_supply,
  input  logic hold_en,
  output logic in_run,
  output logic in_brown,
  output logic in_hold,
  output logic hold_done
);

  localparam int HW = cnt_width(HOLD_CYC);
  localparam logic [HW-1:0] H_LAST = HW'(HOLD_CYC - 1);

  sdg_state_e    state;
  logic [HW-1:0] hold_cnt;

  assign in_run    = (state == ST_RUN);
  assign in_brown  = (state == ST_BROWN);
  assign in_hold   = (state == ST_HOLD);
  assign hold_done = in_hold && !low_supply && (hold_cnt == H_LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state    <= ST_RUN;
      hold_cnt <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          hold_cnt <= '0;
          if (trip) state <= ST_BROWN;
        end
        ST_BROWN: begin
          hold_cnt <= '0;
          if (!low_supply) state <= hold_en ? ST_HOLD : ST_RUN;
        end
        ST_HOLD: begin
          if (low_supply) begin
            state    <= ST_BROWN;
            hold_cnt <= '0;
          end else if (hold_done) begin
            state    <= ST_RUN;
            hold_cnt <= '0;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        default: begin
          state    <= ST_RUN;
          hold_cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdg_flags.sv
module sdg_flags (
  input  logic clk,
  input  logic por_n,
  input  logic ctl_we,
  input  logic ctl_arm,
  input  logic ctl_set_brn,
  input  logic ctl_set_pwr,
  input  logic trip,
  output logic sw_arm,
  output logic brn_flag,
  output logic pwr_flag
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sw_arm   <= 1'b1;
      brn_flag <= 1'b0;
      pwr_flag <= 1'b0;
    end else begin
      if (ctl_we) sw_arm <= ctl_arm;
      if (ctl_we && ctl_set_pwr) pwr_flag <= 1'b1;
      if (trip)                          brn_flag <= 1'b0;
      else if (ctl_we && ctl_set_brn)    brn_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/supply_dip_guard.sv
module supply_dip_guard
  import sdg_pkg::*;
#(
  parameter int FILT_CYC = 8,
  parameter int HOLD_CYC = 32
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       low_supply,
  input  logic [1:0] arm_cfg,
  input  logic       sleep_mode,
  input  logic       hold_en,
  input  logic       ctl_we,
  input  logic       ctl_arm,
  input  logic       ctl_set_brn,
  input  logic       ctl_set_pwr,
  output logic       dev_reset,
  output logic       arm_rd,
  output logic       brn_flag,
  output logic       pwr_flag
);

  logic sw_arm;
  logic live;
  logic count_en;
  logic trip;
  logic in_run;
  logic in_brown;
  logic in_hold;
  logic hold_done;

  sdg_arm_decode u_arm (
    .arm_cfg    (arm_cfg),
    .sw_arm     (sw_arm),
    .sleep_mode (sleep_mode),
    .live       (live),
    .arm_rd     (arm_rd)
  );

  assign count_en = low_supply && live && in_run;

  sdg_dip_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk      (clk),
    .por_n    (por_n),
    .count_en (count_en),
    .trip     (trip)
  );

  sdg_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .trip       (trip),
    .low_supply (low_supply),
    .hold_en    (hold_en),
    .in_run     (in_run),
    .in_brown   (in_brown),
    .in_hold    (in_hold),
    .hold_done  (hold_done)
  );

  sdg_flags u_flags (
    .clk         (clk),
    .por_n       (por_n),
    .ctl_we      (ctl_we),
    .ctl_arm     (ctl_arm),
    .ctl_set_brn (ctl_set_brn),
    .ctl_set_pwr (ctl_set_pwr),
    .trip        (trip),
    .sw_arm      (sw_arm),
    .brn_flag    (brn_flag),
    .pwr_flag    (pwr_flag)
  );

  assign dev_reset = !in_run;

endmodule

// File: rtl/sdg_checker.sv
module sdg_checker (
  input logic       clk,
  input logic       por_n,
  input logic [1:0] arm_cfg,
  input logic       low_supply,
  input logic       dev_reset,
  input logic       arm_rd,
  input logic       brn_flag,
  input logic       pwr_flag,
  input logic       ctl_we,
  input logic       trip,
  input logic       in_hold,
  input logic       in_brown,
  input logic       hold_done
);

  AST_OFF_NO_TRIP: assert property (@(posedge clk) disable iff (!por_n)
    (arm_cfg == 2'b00 && !dev_reset) |=> !dev_reset); // R1

  AST_ARM_RD_MASK: assert property (@(posedge clk) disable iff (!por_n)
    (arm_cfg != 2'b01) |-> !arm_rd); // R5

  AST_TRIP_AFTER_LOW: assert property (@(posedge clk) disable iff (!por_n)
    $rose(dev_reset) |-> $past(low_supply)); // R6

  AST_LOW_KEEPS_RESET: assert property (@(posedge clk) disable iff (!por_n)
    (dev_reset && low_supply) |=> dev_reset); // R7

  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!por_n)
    hold_done |=> !dev_reset); // R8

  AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!por_n)
    (in_hold && low_supply) |=> in_brown); // R9

  AST_TRIP_CLEARS_BRN: assert property (@(posedge clk) disable iff (!por_n)
    trip |=> (dev_reset && !brn_flag)); // R10

  AST_PWR_STEADY: assert property (@(posedge clk) disable iff (!por_n)
    !ctl_we |=> $stable(pwr_flag)); // R11

endmodule

bind supply_dip_guard sdg_checker u_sdg_chk (
  .clk        (clk),
  .por_n      (por_n),
  .arm_cfg    (arm_cfg),
  .low_supply (low_supply),
  .dev_reset  (dev_reset),
  .arm_rd     (arm_rd),
  .brn_flag   (brn_flag),
  .pwr_flag   (pwr_flag),
  .ctl_we     (ctl_we),
  .trip       (trip),
  .in_hold    (in_hold),
  .in_brown   (in_brown),
  .hold_done  (hold_done)
);

// File: tb/supply_dip_guard_bench.sv
`timescale 1ns/1ps
module supply_dip_guard_bench;

  localparam int B_FILT = 8;
  localparam int B_HOLD = 32;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       low_supply = 1'b0;
  logic [1:0] arm_cfg = 2'b11;
  logic       sleep_mode = 1'b0;
  logic       hold_en = 1'b0;
  logic       ctl_we = 1'b0;
  logic       ctl_arm = 1'b0;
  logic       ctl_set_brn = 1'b0;
  logic       ctl_set_pwr = 1'b0;
  logic       dev_reset, arm_rd, brn_flag, pwr_flag;

  int n_chk = 0;
  int n_bad = 0;

  // Bench model state: 0 run, 1 brown-out, 2 hold
  int   m_st, m_dip, m_hold;
  logic m_arm, m_brn, m_pwr;

  always #10 clk = !clk;

  supply_dip_guard #(.FILT_CYC(B_FILT), .HOLD_CYC(B_HOLD)) u_supply_dip_guard (
    .clk (clk), .por_n (por_n), .low_supply (low_supply), .arm_cfg (arm_cfg),
    .sleep_mode (sleep_mode), .hold_en (hold_en), .ctl_we (ctl_we),
    .ctl_arm (ctl_arm), .ctl_set_brn (ctl_set_brn), .ctl_set_pwr (ctl_set_pwr),
    .dev_reset (dev_reset), .arm_rd (arm_rd), .brn_flag (brn_flag),
    .pwr_flag (pwr_flag)
  );

  function automatic logic b_live(logic [1:0] c, logic a, logic s);
    return (c[1] & (c[0] | !s)) | (!c[1] & c[0] & a);
  endfunction

  function automatic logic b_rd(logic [1:0] c, logic a);
    return (c == 2'b01) ? a : 1'b0;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_dip = 0; m_hold = 0;
    m_arm = 1'b1; m_brn = 1'b0; m_pwr = 1'b0;
  endtask

  task automatic compare_all();
    chk("R6/R7/R8 dev_reset", dev_reset, m_st != 0);
    chk("R5 arm_rd", arm_rd, b_rd(arm_cfg, m_arm));
    chk("R10 brn_flag", brn_flag, m_brn);
    chk("R11 pwr_flag", pwr_flag, m_pwr);
  endtask

  task automatic tick();
    int   n_st = m_st, n_dip = 0, n_hold = m_hold;
    logic n_arm = m_arm, n_brn = m_brn, n_pwr = m_pwr, tr = 1'b0;
    case (m_st)
      0: begin
        n_hold = 0;
        if (low_supply && b_live(arm_cfg, m_arm, sleep_mode)) begin
          if (m_dip == B_FILT - 1) begin tr = 1'b1; n_st = 1; end
          else n_dip = m_dip + 1;
        end
      end
      1: begin
        n_hold = 0;
        if (!low_supply) n_st = hold_en ? 2 : 0;
      end
      default: begin
        if (low_supply) begin n_st = 1; n_hold = 0; end
        else if (m_hold == B_HOLD - 1) begin n_st = 0; n_hold = 0; end
        else n_hold = m_hold + 1;
      end
    endcase
    if (ctl_we) begin
      n_arm = ctl_arm;
      if (ctl_set_brn) n_brn = 1'b1;
      if (ctl_set_pwr) n_pwr = 1'b1;
    end
    if (tr) n_brn = 1'b0;
    @(posedge clk); #2;
    m_st = n_st; m_dip = n_dip; m_hold = n_hold;
    m_arm = n_arm; m_brn = n_brn; m_pwr = n_pwr;
    compare_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_por();
    por_n = 1'b0;
    model_reset();
    #25;
    chk("R10 brn_flag after power-on", brn_flag, 1'b0);
    chk("R11 pwr_flag after power-on", pwr_flag, 1'b0);
    chk("R8 dev_reset after power-on", dev_reset, 1'b0);
    por_n = 1'b1;
  endtask

  task automatic write(logic arm, logic sb, logic sp);
    ctl_we = 1'b1; ctl_arm = arm; ctl_set_brn = sb; ctl_set_pwr = sp;
    tick();
    ctl_we = 1'b0; ctl_set_brn = 1'b0; ctl_set_pwr = 1'b0;
  endtask

  initial begin
    #(64'd200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    #5;
    do_por();
    arm_cfg = 2'b01; #1;
    chk("R2 arm bit resets to 1", arm_rd, 1'b1);

    // R1: code 00 never trips
    arm_cfg = 2'b00; low_supply = 1'b1; ticks(20);
    chk("R1 off code holds reset low", dev_reset, 1'b0);
    low_supply = 1'b0; tick();

    // R6: filter boundary under code 11
    arm_cfg = 2'b11; low_supply = 1'b1; ticks(B_FILT - 1);
    low_supply = 1'b0; tick();
    chk("R6 short dip ignored", dev_reset, 1'b0);
    low_supply = 1'b1; ticks(B_FILT);
    chk("R6 full dip trips", dev_reset, 1'b1);
    ticks(15);
    chk("R7 reset held while low", dev_reset, 1'b1);
    hold_en = 1'b0; low_supply = 1'b0; tick();
    chk("R8 no hold releases at once", dev_reset, 1'b0);

    // R8: power-up hold length
    hold_en = 1'b1; low_supply = 1'b1; ticks(B_FILT);
    low_supply = 1'b0; ticks(B_HOLD);
    chk("R8 hold still active", dev_reset, 1'b1);
    tick();
    chk("R8 hold ends", dev_reset, 1'b0);

    // R9: dip during hold restarts it
    low_supply = 1'b1; ticks(B_FILT);
    low_supply = 1'b0; ticks(10);
    low_supply = 1'b1; tick();
    low_supply = 1'b0; ticks(B_HOLD);
    chk("R9 restarted hold still active", dev_reset, 1'b1);
    tick();
    chk("R9 restarted hold ends", dev_reset, 1'b0);

    // R3: code 10 follows sleep
    hold_en = 1'b0; arm_cfg = 2'b10; sleep_mode = 1'b1; low_supply = 1'b1; ticks(20);
    chk("R3 asleep no trip", dev_reset, 1'b0);
    sleep_mode = 1'b0; ticks(B_FILT);
    chk("R3 awake trips", dev_reset, 1'b1);
    low_supply = 1'b0; tick();

    // R2 and R5: code 01 follows the arm bit
    arm_cfg = 2'b01; write(1'b0, 1'b0, 1'b0);
    chk("R5 arm bit 0 reads 0", arm_rd, 1'b0);
    low_supply = 1'b1; ticks(20);
    chk("R2 disarmed no trip", dev_reset, 1'b0);
    low_supply = 1'b0; write(1'b1, 1'b0, 1'b0);
    chk("R5 arm bit 1 reads 1", arm_rd, 1'b1);
    low_supply = 1'b1; ticks(B_FILT);
    chk("R2 armed trips", dev_reset, 1'b1);
    low_supply = 1'b0; tick();

    // R4: code 11 ignores a cleared arm bit
    arm_cfg = 2'b11; write(1'b0, 1'b0, 1'b0);
    chk("R5 code 11 reads 0", arm_rd, 1'b0);
    low_supply = 1'b1; ticks(B_FILT);
    chk("R4 always-on trips", dev_reset, 1'b1);
    low_supply = 1'b0; tick();

    // R10: trip and software set on the same edge
    write(1'b0, 1'b1, 1'b0);
    chk("R10 software set", brn_flag, 1'b1);
    low_supply = 1'b1; ticks(B_FILT - 1);
    write(1'b0, 1'b1, 1'b0);
    chk("R10 trip beats set", brn_flag, 1'b0);
    chk("R10 trip raised reset", dev_reset, 1'b1);
    low_supply = 1'b0; tick();

    // R11: power-on flag survives brown-out
    write(1'b0, 1'b0, 1'b1);
    chk("R11 software set", pwr_flag, 1'b1);
    low_supply = 1'b1; ticks(B_FILT + 3);
    chk("R11 survives brown-out", pwr_flag, 1'b1);
    low_supply = 1'b0; tick();
    do_por();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) low_supply = !low_supply;
      if ($urandom_range(0, 60) == 0) arm_cfg = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 30) == 0) sleep_mode = !sleep_mode;
      if ($urandom_range(0, 40) == 0) hold_en = !hold_en;
      ctl_we = ($urandom_range(0, 7) == 0);
      ctl_arm = 1'($urandom_range(0, 1));
      ctl_set_brn = 1'($urandom_range(0, 1));
      ctl_set_pwr = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 700) == 0) do_por();
      else tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule